// File: doc/BRIEF.md
# Reversible Complete-Sequence LFSR Address Generator

This block supplies memory addresses to a march-style memory self-test engine. Instead of a binary counter it steps a linear feedback shift register. A NOR term over the non-feedback bits is folded into the feedback so that the register passes through the all-zero state, and every one of the 2^W addresses appears exactly once per pass. The register can step forward (the up pass) or exactly backward (the down pass). The backward step is the algebraic inverse of the forward step. Because of this, reversing direction in the middle of a pass moves straight to the previous address and never repeats a cycle.

Each step shifts exactly one new bit into the register, and that bit is also driven on a serial pin. A single wire can therefore feed shift registers next to several memories. Each of those receiver registers holds the same address as the generator once W steps have been made in one direction. A synchronous start input loads the first address of the chosen pass. A one-cycle flag marks the final address of that pass. The march element sequencing, the data backgrounds and the memories themselves sit outside this block.

Top module: `cl_addr_gen`

## Requirements
- R1: An enabled up step (dir_down_i = 0) shifts the address left by one. The new bit 0 is the old bit W-1, XOR the tap bits of the width's tap set, XOR the NOR of old bits W-2..0. For W = 6 the tap set is bit 4, so new bit 0 = a[5] ^ a[4] ^ (a[4:0] == 0).
- R2: After a start in the up direction, 2^W - 1 enabled up steps visit every W-bit address exactly once. The next step returns to SEED.
- R3: An enabled down step (dir_down_i = 1) undoes one up step: it shifts right and recovers the old bit W-1. A down pass is the exact reverse of the up pass, and an up step followed by a down step restores the address.
- R4: Every enabled step without start gives an address that differs from the previous one, including the cycles where the direction changes.
- R5: start_i loads SEED when dir_down_i = 0. It loads the address that precedes SEED in up order (6'h20 for W = 6 and SEED = 0) when dir_down_i = 1. start_i takes priority over en_i.
- R6: last_o is 1 for exactly the cycle in which a step has just produced the final address of its direction: the predecessor of SEED for up, SEED for down. It is 0 at all other times, including after a start.
- R7: After an up step ser_o equals addr_o[0], and after a down step ser_o equals addr_o[W-1]. A receiver that shifts ser_o in the same direction holds addr_o after W steps.
- R8: With en_i = 0 and start_i = 0, addr_o holds its value and last_o is 0.
- R9: While rst_n is low, addr_o is SEED, last_o is 0 and the direction is up, so ser_o equals addr_o[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Take one step this cycle |
| dir_down_i | input | 1 | 0 = up step, 1 = down step; also selects the start address |
| start_i | input | 1 | Load the first address of the selected pass |
| addr_o | output | W | Current address |
| ser_o | output | 1 | Bit shifted in by the latest step |
| last_o | output | 1 | Final address of the current pass is on addr_o |

## Verification
On every cycle the checker confirms the following local properties: the one-bit shift of each step, that each step changes the address, that an up step followed by a down step undoes itself, the start targets, the serial bit position, holding, and that last_o never lasts two cycles. Only the bench scenarios can show the global properties. These are that a full up pass covers all 2^W addresses with none repeated, that the down pass replays the recorded up pass backwards, that last_o falls on exactly the 2^W-th address, and that a serial receiver ends up holding the parallel address.

// File: rtl/cl_addr_pkg.sv
package cl_addr_pkg;

  // Feedback taps among bits W-2..0 (bit W-1 always feeds back).
  // Each set is a maximal-length recurrence for its width.
  function automatic logic [15:0] tap_mask(input int unsigned w);
    case (w)
      3:       return 16'h0002;
      4:       return 16'h0004;
      5:       return 16'h0004;
      6:       return 16'h0010;
      7:       return 16'h0020;
      8:       return 16'h0038;
      9:       return 16'h0010;
      10:      return 16'h0040;
      11:      return 16'h0100;
      12:      return 16'h0029;
      13:      return 16'h000D;
      14:      return 16'h0015;
      15:      return 16'h2000;
      16:      return 16'h5008;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] low_mask(input int unsigned w);
    return (16'h1 << (w - 1)) - 16'h1;
  endfunction

  function automatic logic [15:0] full_mask(input int unsigned w);
    return (w >= 16) ? 16'hFFFF : ((16'h1 << w) - 16'h1);
  endfunction

  // Feedback contribution of the bits that stay in the register:
  // linear taps plus the zero-insertion NOR term.
  function automatic logic fb_bit(input logic [15:0] rest, input int unsigned w);
    logic lin;
    logic nor_t;
    lin   = ^(rest & tap_mask(w));
    nor_t = ((rest & low_mask(w)) == 16'h0);
    return lin ^ nor_t;
  endfunction

  function automatic logic [15:0] fwd_step(input logic [15:0] s, input int unsigned w);
    logic [15:0] rest;
    logic        msb;
    logic        nb;
    rest = s & low_mask(w);
    msb  = ((s >> (w - 1)) & 16'h1) != 16'h0;
    nb   = msb ^ fb_bit(rest, w);
    return ((s << 1) & full_mask(w)) | {15'h0, nb};
  endfunction

  function automatic logic [15:0] rev_step(input logic [15:0] s, input int unsigned w);
    logic [15:0] rest;
    logic        top;
    rest = (s >> 1) & low_mask(w);
    top  = s[0] ^ fb_bit(rest, w);
    return rest | ({15'h0, top} << (w - 1));
  endfunction

endpackage

// File: rtl/cl_step.sv
module cl_step
  import cl_addr_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] fwd_o,
  output logic [W-1:0] rev_o
);
  localparam int unsigned PAD = 16 - W;

  logic [15:0] cur_wide;
  logic [15:0] fwd_wide;
  logic [15:0] rev_wide;

  generate
    if (PAD == 0) begin : g_full
      assign cur_wide = cur_i;
    end else begin : g_pad
      assign cur_wide = {{PAD{1'b0}}, cur_i};
    end
  endgenerate

  assign fwd_wide = fwd_step(cur_wide, W);
  assign rev_wide = rev_step(cur_wide, W);
  assign fwd_o    = fwd_wide[W-1:0];
  assign rev_o    = rev_wide[W-1:0];
endmodule

// File: rtl/cl_end_detect.sv
module cl_end_detect #(
  parameter int unsigned      W      = 6,
  parameter logic [W-1:0]     UP_END = '0,
  parameter logic [W-1:0]     DN_END = '0
) (
  input  logic [W-1:0] nxt_i,
  input  logic         dir_down_i,
  output logic         end_o
);
  assign end_o = dir_down_i ? (nxt_i == DN_END) : (nxt_i == UP_END);
endmodule

// File: rtl/cl_serial_sel.sv
module cl_serial_sel #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] addr_i,
  input  logic         dir_down_i,
  output logic         ser_o
);
  // The freshly inserted bit sits at the end the shift moved away from.
  assign ser_o = dir_down_i ? addr_i[W-1] : addr_i[0];
endmodule

// File: rtl/cl_addr_gen.sv
module cl_addr_gen
  import cl_addr_pkg::*;
#(
  parameter int unsigned  W    = 6,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         dir_down_i,
  input  logic         start_i,
  output logic [W-1:0] addr_o,
  output logic         ser_o,
  output logic         last_o
);
  localparam logic [15:0]  SEED_WIDE = 16'(SEED);
  localparam logic [15:0]  PRED_WIDE = rev_step(SEED_WIDE, W);
  localparam logic [W-1:0] PRED      = PRED_WIDE[W-1:0];

  logic [W-1:0] addr_q;
  logic         dir_q;
  logic         last_q;

  // Named internal events
  logic [W-1:0] step_fwd;
  logic [W-1:0] step_rev;
  logic [W-1:0] step_nxt;
  logic         step_go;
  logic         load_go;
  logic         hits_end;
  logic [W-1:0] load_val;

  cl_step #(.W(W)) u_step (
    .cur_i (addr_q),
    .fwd_o (step_fwd),
    .rev_o (step_rev)
  );

  cl_end_detect #(.W(W), .UP_END(PRED), .DN_END(SEED)) u_end (
    .nxt_i      (step_nxt),
    .dir_down_i (dir_down_i),
    .end_o      (hits_end)
  );

  cl_serial_sel #(.W(W)) u_ser (
    .addr_i     (addr_q),
    .dir_down_i (dir_q),
    .ser_o      (ser_o)
  );

  assign load_go  = start_i;
  assign step_go  = en_i && !start_i;
  assign step_nxt = dir_down_i ? step_rev : step_fwd;
  assign load_val = dir_down_i ? PRED : SEED;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= SEED;
      dir_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (load_go) begin
      addr_q <= load_val;
      dir_q  <= dir_down_i;
      last_q <= 1'b0;
    end else if (step_go) begin
      addr_q <= step_nxt;
      dir_q  <= dir_down_i;
      last_q <= hits_end;
    end else begin
      last_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign last_o = last_q;
endmodule

// File: rtl/cl_addr_gen_chk.sv
module cl_addr_gen_chk
  import cl_addr_pkg::*;
#(
  parameter int unsigned  W    = 6,
  parameter logic [W-1:0] SEED = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic         dir_down_i,
  input logic         start_i,
  input logic [W-1:0] addr_o,
  input logic         ser_o,
  input logic         last_o
);
  localparam logic [15:0]  PW   = rev_step(16'(SEED), W);
  localparam logic [W-1:0] PRED = PW[W-1:0];

  logic up_go;
  logic dn_go;
  assign up_go = en_i && !start_i && !dir_down_i;
  assign dn_go = en_i && !start_i && dir_down_i;

  a_r1_up_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_go |=> addr_o[W-1:1] == $past(addr_o[W-2:0]));

  a_r3_dn_shift: assert property (@(posedge clk) disable iff (!rst_n)
    dn_go |=> addr_o[W-2:0] == $past(addr_o[W-1:1]));

  a_r3_undo: assert property (@(posedge clk) disable iff (!rst_n)
    up_go ##1 dn_go |=> addr_o == $past(addr_o, 2));

  a_r4_fresh_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_i) |=> addr_o != $past(addr_o));

  a_r5_start_up: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !dir_down_i) |=> addr_o == SEED && !last_o);

  a_r5_start_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && dir_down_i) |=> addr_o == PRED && !last_o);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !last_o);

  a_r7_ser_up: assert property (@(posedge clk) disable iff (!rst_n)
    up_go |=> ser_o == addr_o[0]);

  a_r7_ser_dn: assert property (@(posedge clk) disable iff (!rst_n)
    dn_go |=> ser_o == addr_o[W-1]);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !start_i) |=> $stable(addr_o) && !last_o);
endmodule

bind cl_addr_gen cl_addr_gen_chk #(.W(W), .SEED(SEED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .dir_down_i (dir_down_i),
  .start_i    (start_i),
  .addr_o     (addr_o),
  .ser_o      (ser_o),
  .last_o     (last_o)
);

// File: tb/sim_cl_addr_gen.sv
`timescale 1ns/1ps
module sim_cl_addr_gen;
  localparam int W = 6;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic dir_down_i = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] addr_o;
  logic ser_o;
  logic last_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [W-1:0] up_seq [N];

  always #4 clk = ~clk;

  cl_addr_gen #(.W(W), .SEED(6'h00)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .dir_down_i(dir_down_i),
    .start_i(start_i), .addr_o(addr_o), .ser_o(ser_o), .last_o(last_o)
  );

  function automatic logic [W-1:0] model_up(input logic [W-1:0] a);
    logic nb;
    nb = a[5] ^ a[4] ^ (a[4:0] == 5'd0);
    return {a[4:0], nb};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    tick(); tick();
    chk("R9", "reset addr", 32'(addr_o), 32'h00);
    chk("R9", "reset last", 32'(last_o), 32'h0);
    chk("R9", "reset ser", 32'(ser_o), 32'(addr_o[0]));
    rst_n = 1'b1;
  endtask

  task automatic t_up_pass;
    bit seen [N];
    logic [W-1:0] rx;
    logic [W-1:0] prev;
    int dups;
    for (int i = 0; i < N; i++) seen[i] = 1'b0;
    dups = 0;
    rx = '0;
    start_i = 1'b1; dir_down_i = 1'b0; en_i = 1'b0;
    tick();
    chk("R5", "up start", 32'(addr_o), 32'h00);
    chk("R6", "last after start", 32'(last_o), 32'h0);
    up_seq[0] = addr_o;
    seen[addr_o] = 1'b1;
    start_i = 1'b0; en_i = 1'b1;
    for (int k = 1; k < N; k++) begin
      prev = addr_o;
      tick();
      chk("R1", "up step", 32'(addr_o), 32'(model_up(prev)));
      chk("R6", "up last flag", 32'(last_o), (k == N - 1) ? 32'h1 : 32'h0);
      chk("R7", "up ser bit", 32'(ser_o), 32'(addr_o[0]));
      rx = {rx[W-2:0], ser_o};
      if (k >= W) chk("R7", "up receiver", 32'(rx), 32'(addr_o));
      up_seq[k] = addr_o;
      if (seen[addr_o]) dups++;
      seen[addr_o] = 1'b1;
    end
    chk("R2", "duplicates in up pass", 32'(dups), 32'h0);
    chk("R1", "first step from zero", 32'(up_seq[1]), 32'h01);
    chk("R5", "up end is predecessor", 32'(up_seq[N-1]), 32'h20);
    tick();
    chk("R2", "wrap to seed", 32'(addr_o), 32'h00);
    chk("R6", "last cleared after wrap", 32'(last_o), 32'h0);
    en_i = 1'b0;
  endtask

  task automatic t_down_pass;
    logic [W-1:0] rx;
    rx = '0;
    start_i = 1'b1; dir_down_i = 1'b1; en_i = 1'b0;
    tick();
    chk("R5", "down start", 32'(addr_o), 32'(up_seq[N-1]));
    start_i = 1'b0; en_i = 1'b1;
    for (int k = 1; k < N; k++) begin
      tick();
      chk("R3", "down order", 32'(addr_o), 32'(up_seq[N-1-k]));
      chk("R6", "down last flag", 32'(last_o), (k == N - 1) ? 32'h1 : 32'h0);
      chk("R7", "down ser bit", 32'(ser_o), 32'(addr_o[W-1]));
      rx = {ser_o, rx[W-1:1]};
      if (k >= W) chk("R7", "down receiver", 32'(rx), 32'(addr_o));
    end
    en_i = 1'b0;
    tick();
    chk("R8", "hold after down end", 32'(addr_o), 32'h00);
    chk("R8", "last drops on hold", 32'(last_o), 32'h0);
  endtask

  task automatic t_switch;
    logic [W-1:0] prev;
    start_i = 1'b1; dir_down_i = 1'b0; en_i = 1'b0;
    tick();
    start_i = 1'b0; en_i = 1'b1;
    for (int k = 1; k <= 5; k++) tick();
    chk("R1", "five up steps", 32'(addr_o), 32'(up_seq[5]));
    prev = addr_o; dir_down_i = 1'b1; tick();
    chk("R4", "up->down differs", 32'(addr_o != prev), 32'h1);
    chk("R3", "up->down reverse", 32'(addr_o), 32'(up_seq[4]));
    prev = addr_o; tick();
    chk("R3", "second down step", 32'(addr_o), 32'(up_seq[3]));
    prev = addr_o; dir_down_i = 1'b0; tick();
    chk("R4", "down->up differs", 32'(addr_o != prev), 32'h1);
    chk("R3", "down->up forward", 32'(addr_o), 32'(up_seq[4]));
    en_i = 1'b0;
  endtask

  task automatic t_hold_and_priority;
    logic [W-1:0] held;
    held = addr_o;
    en_i = 1'b0; start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      dir_down_i = k[0];
      tick();
      chk("R8", "hold addr", 32'(addr_o), 32'(held));
      chk("R8", "hold last", 32'(last_o), 32'h0);
    end
    en_i = 1'b1; start_i = 1'b1; dir_down_i = 1'b1;
    tick();
    chk("R5", "start beats enable", 32'(addr_o), 32'h20);
    start_i = 1'b0; en_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_up_pass();
    t_down_pass();
    t_switch();
    t_hold_and_priority();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule